// File: doc/BRIEF.md
# Data-Ready Triggered SPI Burst Reader

This block reads an external converter with no help from software. It watches the converter's active-low data-ready line. Each time that line goes from high to low, the block runs one SPI read burst of fixed length, with the serial clock idle low. It assembles the returned serial bits into 32-bit words and queues the whole frame in a word FIFO. The host may read that FIFO much later without losing data.

A divider input sets the serial clock speed. The value is the number of system clocks in each half of a serial clock period. With a 100 MHz system clock, a value of 50 gives a 1 MHz serial clock. The start latency is fixed at a few system clocks plus one half period, so the first clock edge arrives well inside a 20 µs window.

The block never drops anything silently. Two sticky flags report trouble. One flags a data-ready edge that arrived while a burst was in progress. The other flags a frame that was refused because the FIFO had no room for it.

Top module: `drdy_spi_burst_reader`

## Requirements
- R1: Only a high-to-low transition of `drdy` starts a burst, and only after a two-flop synchronizer. If `drdy` is low at edge k and was high at edge k-1, `csn` drives low after edge k+2. Holding `drdy` low never starts a second burst.
- R2: Each accepted burst gives exactly 96 `sclk` pulses, and `sclk` is low whenever `csn` is high. Each high phase and each low phase of `sclk` lasts `half_div` system clocks. A `half_div` of 0 acts as 1.
- R3: Chip select surrounds the clock with one half period at each end. The first `sclk` rise comes `half_div` clocks after `csn` falls. `csn` rises `half_div` clocks after the 96th `sclk` fall.
- R4: `miso` is sampled on every rising `sclk` edge. The bits fill three words MSB first: the first bit goes to bit 31 of word 0, and the last bit goes to bit 0 of word 2. The words are written on the three clocks after `csn` rises, in the order word 0, word 1, word 2.
- R5: `mosi` stays at 0 at all times.
- R6: The burst stays busy from the start edge until the third word has been written. A falling edge evaluated during that time sets the sticky flag `missed_evt` and does not restart or extend the burst. An edge evaluated on the first clock after the busy time starts a new burst.
- R7: When the FIFO already holds more than `FIFO_DEPTH`-3 words at the moment an event is evaluated, no burst runs. In that case `csn` stays high, no word is written, and the sticky flag `overflow` is set.
- R8: The FIFO is show-ahead. `rd_valid` is high while it holds at least one word, and `rd_data` shows the oldest word. `rd_en` removes that word at the next clock edge. `rd_en` has no effect when the FIFO is empty. A read and a write on the same clock leave the word count unchanged.
- R9: While `rst` is high and after it is released, `csn` is 1, `sclk` is 0, `rd_valid` is 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_div | input | 16 | System clocks per serial-clock half period |
| drdy | input | 1 | Asynchronous data-ready from the converter, active low |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| csn | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the converter, held at 0 |
| rd_en | input | 1 | Host removes the word at the head of the FIFO |
| rd_data | output | 32 | Word at the head of the FIFO |
| rd_valid | output | 1 | FIFO holds at least one word |
| missed_evt | output | 1 | Sticky: a data-ready edge arrived while a burst was busy |
| overflow | output | 1 | Sticky: a frame was refused for lack of FIFO room |

## Verification
Two pairs of functions can fall on the same clock. The first pair is a host read and a frame write: the host holds `rd_en` high through the end of a burst, so the pop of word 0 lands on the same edge as the write of word 1. The per-clock model then checks that `rd_valid` and the data order are correct. The second pair is a new data-ready edge and the end of the busy time: the bench times one edge for the last clock of the busy time, which must give `missed_evt`, and another for the first free clock, which must start a clean burst. A run of frames with no reads then fills the FIFO, so the room check meets an event, and the model judges whether a burst starts or `overflow` is set.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL,
        ST_PUSH
    } burst_state_e;

endpackage

// File: rtl/drdy_edge_detect.sv
module drdy_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic drdy,
    output logic fall_evt
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = drdy;
        r_d.sync = r_q.meta;
        r_d.prev = r_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign fall_evt = r_q.prev & ~r_q.sync;

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> !fall_evt);  // R1

endmodule

// File: rtl/frame_fifo.sv
module frame_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    parameter int FRAME_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              room_ok
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic do_pop;

    assign do_pop = rd_en && (r_q.count != '0);

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.wptr = (r_q.wptr == AW'(DEPTH - 1)) ? '0 : r_q.wptr + 1'b1;
        end
        if (do_pop) begin
            r_d.rptr = (r_q.rptr == AW'(DEPTH - 1)) ? '0 : r_q.rptr + 1'b1;
        end
        case ({wr_en, do_pop})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[r_q.wptr] <= wr_data;
        end
    end

    assign rd_data  = mem_q[r_q.rptr];
    assign rd_valid = (r_q.count != '0);
    assign room_ok  = (r_q.count <= CW'(DEPTH - FRAME_WORDS));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (r_q.count < CW'(DEPTH)));  // R7
    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_valid && !wr_en) |=> !rd_valid);  // R8
    AST_SAME_CYCLE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && rd_valid) |=> $stable(r_q.count));  // R8

endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import spi_burst_pkg::*;
#(
    parameter int FRAME_BITS = 96,
    parameter int WORD_W     = 32,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              fall_evt,
    input  logic              miso,
    input  logic              room_ok,
    output logic              sclk,
    output logic              csn,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              missed_evt,
    output logic              overflow
);

    localparam int WORDS     = FRAME_BITS / WORD_W;
    localparam int BIT_CNT_W = $clog2(FRAME_BITS + 1);
    localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;

    typedef struct packed {
        burst_state_e            st;
        logic [DIV_W-1:0]        cnt;
        logic [BIT_CNT_W-1:0]    bits;
        logic [WIDX_W-1:0]       widx;
        logic [FRAME_BITS-1:0]   shreg;
        logic                    sclk;
        logic                    csn;
        logic                    missed;
        logic                    ovf;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [DIV_W-1:0] last_cnt;
    logic             tick;

    assign last_cnt = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick     = (r_q.cnt >= last_cnt);

    always_comb begin
        r_d = r_q;
        if (fall_evt && r_q.st != ST_IDLE) begin
            r_d.missed = 1'b1;
        end
        case (r_q.st)
            ST_IDLE: begin
                r_d.cnt = '0;
                if (fall_evt) begin
                    if (room_ok) begin
                        r_d.st   = ST_LEAD;
                        r_d.csn  = 1'b0;
                        r_d.bits = '0;
                    end else begin
                        r_d.ovf = 1'b1;
                    end
                end
            end
            ST_LEAD, ST_LOW: begin
                if (tick) begin
                    r_d.cnt   = '0;
                    r_d.sclk  = 1'b1;
                    r_d.shreg = {r_q.shreg[FRAME_BITS-2:0], miso};
                    r_d.st    = ST_HIGH;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b0;
                    r_d.bits = r_q.bits + 1'b1;
                    r_d.st   = (r_q.bits == BIT_CNT_W'(FRAME_BITS - 1)) ? ST_TRAIL : ST_LOW;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    r_d.cnt  = '0;
                    r_d.csn  = 1'b1;
                    r_d.widx = '0;
                    r_d.st   = ST_PUSH;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PUSH: begin
                r_d.widx = r_q.widx + 1'b1;
                if (r_q.widx == WIDX_W'(WORDS - 1)) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, cnt: '0, bits: '0, widx: '0, shreg: '0,
                     sclk: 1'b0, csn: 1'b1, missed: 1'b0, ovf: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        wr_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (r_q.widx == WIDX_W'(w)) begin
                wr_data = r_q.shreg[FRAME_BITS-1-w*WORD_W -: WORD_W];
            end
        end
    end

    assign wr_en      = (r_q.st == ST_PUSH);
    assign sclk       = r_q.sclk;
    assign csn        = r_q.csn;
    assign missed_evt = r_q.missed;
    assign overflow   = r_q.ovf;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        csn |-> !sclk);  // R2
    AST_FULL_BIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(csn) |-> (r_q.bits == BIT_CNT_W'(FRAME_BITS)));  // R2
    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(csn) |-> $past(fall_evt));  // R1
    AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (rst)
        missed_evt |=> missed_evt);  // R6
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);  // R7
    AST_REFUSED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && !room_ok && r_q.st == ST_IDLE) |=> csn);  // R7

endmodule

// File: rtl/drdy_spi_burst_reader.sv
module drdy_spi_burst_reader #(
    parameter int FRAME_BITS = 96,
    parameter int WORD_W     = 32,
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              drdy,
    input  logic              miso,
    output logic              sclk,
    output logic              csn,
    output logic              mosi,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              missed_evt,
    output logic              overflow
);

    localparam int FRAME_WORDS = FRAME_BITS / WORD_W;

    logic              fall_evt;
    logic              room_ok;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;

    drdy_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .drdy     (drdy),
        .fall_evt (fall_evt)
    );

    burst_sequencer #(
        .FRAME_BITS (FRAME_BITS),
        .WORD_W     (WORD_W),
        .DIV_W      (DIV_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .half_div   (half_div),
        .fall_evt   (fall_evt),
        .miso       (miso),
        .room_ok    (room_ok),
        .sclk       (sclk),
        .csn        (csn),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .missed_evt (missed_evt),
        .overflow   (overflow)
    );

    frame_fifo #(
        .WORD_W      (WORD_W),
        .DEPTH       (FIFO_DEPTH),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .room_ok  (room_ok)
    );

    assign mosi = 1'b0;

endmodule

// File: tb/drdy_spi_burst_reader_bench.sv
module drdy_spi_burst_reader_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] half_div = 16'd2;
    logic        drdy = 1'b1;
    logic        miso = 1'b0;
    logic        rd_en = 1'b0;
    logic        sclk, csn, mosi, rd_valid, missed_evt, overflow;
    logic [31:0] rd_data;

    drdy_spi_burst_reader u_drdy_spi_burst_reader (
        .clk(clk), .rst(rst), .half_div(half_div), .drdy(drdy), .miso(miso),
        .sclk(sclk), .csn(csn), .mosi(mosi), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .missed_evt(missed_evt), .overflow(overflow)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model state
    int          t0 = -1;
    int          hh = 2;
    int          next_free = 0;
    int          evq[$];
    int          push_edge[$];
    logic [31:0] push_word[$];
    logic [31:0] wq[$];
    logic        prev_drdy = 1'b1;
    logic        exp_missed = 1'b0;
    logic        exp_ovf = 1'b0;
    logic [95:0] pat = '0;
    logic [95:0] act_pat = '0;
    logic [31:0] last_rd_data = '0;
    logic        last_rd_valid = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            chk(csn === 1'b1, "R9", "csn in reset", {31'd0, csn}, 32'd1);
            chk(sclk === 1'b0, "R9", "sclk in reset", {31'd0, sclk}, 32'd0);
            chk(rd_valid === 1'b0, "R9", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
            chk({missed_evt, overflow} === 2'b00, "R9", "flags in reset",
                {30'd0, missed_evt, overflow}, 32'd0);
        end else begin
            automatic int n = cyc;
            automatic int occ = wq.size();
            automatic logic e_csn, e_sclk;
            // event detection (two-flop sync, then edge)
            if (prev_drdy && !drdy) evq.push_back(n + 2);
            prev_drdy = drdy;
            if (evq.size() > 0 && evq[0] == n) begin
                void'(evq.pop_front());
                if (n < next_free) begin
                    exp_missed = 1'b1;
                end else if (occ > DEPTH - 3) begin
                    exp_ovf = 1'b1;
                end else begin
                    t0 = n;
                    hh = (half_div == 16'd0) ? 1 : int'(half_div);
                    act_pat = pat;
                    next_free = n + 193 * hh + 4;
                    for (int w = 0; w < 3; w++) begin
                        push_edge.push_back(n + 193 * hh + 1 + w);
                        push_word.push_back(pat[95 - 32 * w -: 32]);
                    end
                end
            end
            // host read at this edge
            if (rd_en && occ > 0) begin
                chk(last_rd_data === wq[0], "R4", "frame word order/content", last_rd_data, wq[0]);
                void'(wq.pop_front());
            end
            if (push_edge.size() > 0 && push_edge[0] == n) begin
                void'(push_edge.pop_front());
                wq.push_back(push_word.pop_front());
            end
            // expected pins
            e_csn = 1'b1;
            e_sclk = 1'b0;
            if (t0 >= 0 && n >= t0 && n < t0 + 193 * hh) begin
                e_csn = 1'b0;
                if (n >= t0 + hh) begin
                    automatic int ph = (n - t0 - hh) / hh;
                    e_sclk = (ph % 2 == 0) && (ph < 192);
                end
            end
            chk(csn === e_csn, "R1", "csn timing", {31'd0, csn}, {31'd0, e_csn});
            chk(sclk === e_sclk, "R3", "sclk timing", {31'd0, sclk}, {31'd0, e_sclk});
            chk(mosi === 1'b0, "R5", "mosi idle", {31'd0, mosi}, 32'd0);
            chk(missed_evt === exp_missed, "R6", "missed flag", {31'd0, missed_evt}, {31'd0, exp_missed});
            chk(overflow === exp_ovf, "R7", "overflow flag", {31'd0, overflow}, {31'd0, exp_ovf});
            chk(rd_valid === (wq.size() > 0), "R8", "rd_valid", {31'd0, rd_valid},
                {31'd0, wq.size() > 0});
            last_rd_data = rd_data;
            last_rd_valid = rd_valid;
            // model slave: mode 0, next bit ready before each rising edge
            if (t0 >= 0) begin
                automatic int i = 0;
                if (n + 1 >= t0 + hh) i = (n + 1 - t0 - hh + 2 * hh - 1) / (2 * hh);
                if (i > 95) i = 95;
                miso <= act_pat[95 - i];
            end
        end
    end

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic fire(input int low_len);
        @(negedge clk);
        #1 drdy = 1'b0;
        wait_cyc(low_len);
        #1 drdy = 1'b1;
    endtask

    task automatic wait_idle();
        while (cyc < next_free + 3) @(negedge clk);
    endtask

    task automatic fire_at_eval(input int eval_edge);
        // drdy low sampled at eval_edge-2, event evaluated at eval_edge
        while (cyc < eval_edge - 3) @(negedge clk);
        #1 drdy = 1'b0;
        wait_cyc(4);
        #1 drdy = 1'b1;
    endtask

    task automatic drain();
        @(negedge clk);
        #1 rd_en = 1'b1;
        while (wq.size() > 0 || rd_valid) @(negedge clk);
        wait_cyc(3);
        #1 rd_en = 1'b0;
    endtask

    initial begin
        wait_cyc(4);
        #1 rst = 1'b0;
        wait_cyc(5);
        // R1 R2 R3 R4: basic frame, half_div 2
        pat = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF};
        fire(10);
        wait_idle();
        // R1: drdy held low for longer than a burst, one burst only
        pat = {32'hFFFF0000, 32'h0000FFFF, 32'hA5A5A5A5};
        fire(900);
        wait_idle();
        // R6 boundary: event evaluated on last busy cycle is missed
        pat = {32'h13579BDF, 32'h2468ACE0, 32'hC3C3C33C};
        fire(5);
        fire_at_eval(next_free - 1);
        wait_cyc(20);
        // R6 boundary: event on first free cycle starts a fresh burst
        pat = {32'h0F0F0F0F, 32'hF0F0F0F0, 32'h80000001};
        fire(5);
        pat = {32'h55555555, 32'hAAAAAAAA, 32'h12345678};
        fire_at_eval(next_free);
        wait_cyc(5);
        // R6: event mid-burst ignored
        fire(5);
        wait_idle();
        drain();
        // R8: reads while empty do nothing
        #1 rd_en = 1'b1;
        wait_cyc(6);
        // R8: host reading through frame write (same-cycle pop/push)
        pat = {$urandom, $urandom, $urandom};
        fire(5);
        wait_idle();
        wait_cyc(4);
        #1 rd_en = 1'b0;
        // R2: other divider values, including 0 acting as 1
        half_div = 16'd3;
        pat = {$urandom, $urandom, $urandom};
        fire(5);
        wait_idle();
        half_div = 16'd1;
        pat = {$urandom, $urandom, $urandom};
        fire(5);
        wait_idle();
        half_div = 16'd0;
        pat = {$urandom, $urandom, $urandom};
        fire(5);
        wait_idle();
        drain();
        // R7: fill FIFO without reading until a frame is refused
        half_div = 16'd1;
        for (int f = 0; f < 23; f++) begin
            pat = {$urandom, $urandom, $urandom};
            fire(4);
            wait_idle();
        end
        chk(exp_ovf === 1'b1, "R7", "fill reached refusal", {31'd0, exp_ovf}, 32'd1);
        drain();
        chk(wq.size() == 0, "R8", "all frames drained", wq.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule